// File: doc/BRIEF.md
# Blocked-Access Violation Recorder

This block sits next to a memory access filter and takes note of the accesses the filter refuses. Each refused access reaches it as a single-cycle event. The event carries the target address, a 16-bit master identifier, the requester's security state and the lookup bit of the block that was hit. The block keeps a one-bit violation status and raises a level interrupt while that status and an enable bit are both set. It returns at once whether the refused access must end with a bus error.

Only the first violation is recorded. While the status is set, the two capture registers hold their values and later events are counted as nothing more than repeats. Software clears the status to re-arm the capture, and it can also force the status set to test the interrupt path. A simple register port with a write strobe, a 3-bit register index and 32-bit data gives access to the status, enable, clear, set and capture registers. Reads are combinational from the stored state.

Top module: `viol_capture_irq`

## Requirements
- R1: The interrupt output is high exactly when the status bit and the enable bit are both 1.
- R2: An event that arrives while the status is 0 loads the event address, zero-extended, into the first capture register (index 4) and sets the status at the next clock edge.
- R3: On that capture, the second capture register (index 5) holds the master ID in bits 15:0, the inverse of the requester's secure flag in bit 16, the block lookup bit in bit 17 and zeros in bits 31:18.
- R4: An event that arrives while the status is 1 leaves both capture registers unchanged, and the status stays 1.
- R5: A write to index 2 with data bit 0 high clears the status. A write to index 3 with data bit 0 high sets it. With data bit 0 low, neither write has any effect.
- R6: Reset is synchronous and active low. It leaves enable at 1 and status, both capture registers and the interrupt at 0.
- R7: The error-response output is high in a cycle with an event exactly when the error-response configuration input is high, and it is low in any cycle without an event.
- R8: When a clear write and an event fall in the same cycle, the event wins: the status ends up 1, and if the status was 0 beforehand the capture registers are loaded.
- R9: A write to index 1 stores only data bit 0 as the enable. While the lockdown input is high, such writes leave the enable unchanged.
- R10: Reading index 0 returns the status in bit 0, and reading index 1 returns the enable in bit 0, with all other bits zero. Indices 2, 3, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid_i | input | 1 | Single-cycle refused-access event |
| ev_addr_i | input | ADDR_W | Address of the refused access |
| ev_master_i | input | 16 | Master identifier of the requester |
| ev_secure_i | input | 1 | Requester was in the secure state |
| ev_lut_bit_i | input | 1 | Lookup bit of the block that was hit |
| cfg_err_resp_i | input | 1 | Refused accesses end with a bus error |
| cfg_lockdown_i | input | 1 | Enable register is write-protected |
| ev_bus_err_o | output | 1 | Refused access in this cycle gets a bus error |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench applies random streams of events mixed with random register writes. Some events land while the status is clear and others while it is set, so a capture that fails to freeze shows up as changed capture data. Writes to clear, set and enable, made with bit 0 both high and low, separate real commands from writes that must have no effect. Directed cases place a clear and an event in the same cycle, write the enable under lockdown, and check field placement with master IDs and flags chosen so that each field is distinct.

// File: rtl/viol_capture_pkg.sv
// Shared types for the violation recorder: register indices and the
// layout of the second capture word.
package viol_capture_pkg;
    localparam int REG_AW  = 3;
    localparam int DATA_W  = 32;
    localparam int MID_W   = 16;

    typedef enum logic [REG_AW-1:0] {
        RG_STAT  = 3'd0,
        RG_EN    = 3'd1,
        RG_CLR   = 3'd2,
        RG_SET   = 3'd3,
        RG_INFO1 = 3'd4,
        RG_INFO2 = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-MID_W-3:0] rsvd;
        logic                    lut_bit;
        logic                    nonsec;
        logic [MID_W-1:0]        master;
    } info2_t;
endpackage

// File: rtl/viol_reg_decode.sv
// Register port decoder. Turns the write strobe into one-cycle command
// pulses and muxes stored state onto the read data.
// Assumes: reads are combinational; unmapped indices read zero.
module viol_reg_decode
    import viol_capture_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              stat_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] info1_i,
    input  info2_t            info2_i,
    output logic              clr_cmd_o,
    output logic              set_cmd_o,
    output logic              en_we_o,
    output logic              en_wbit_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] info1_ext;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:1];

    // Zero-extend the captured address to the data width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign info1_ext = {{PAD_W{1'b0}}, info1_i};
        end else begin : g_nopad
            assign info1_ext = info1_i[DATA_W-1:0];
        end
    endgenerate

    // Write command pulses; only bit 0 of the data carries meaning.
    always_comb begin
        clr_cmd_o = reg_we_i && (reg_idx_i == RG_CLR) && reg_wdata_i[0];
        set_cmd_o = reg_we_i && (reg_idx_i == RG_SET) && reg_wdata_i[0];
        en_we_o   = reg_we_i && (reg_idx_i == RG_EN);
        en_wbit_o = reg_wdata_i[0];
    end

    // Read mux over the stored registers.
    always_comb begin
        rdata_o = '0;
        case (reg_idx_i)
            RG_STAT:  rdata_o[0] = stat_i;
            RG_EN:    rdata_o[0] = en_i;
            RG_INFO1: rdata_o    = info1_ext;
            RG_INFO2: rdata_o    = info2_i;
            default:  rdata_o    = '0;
        endcase
    end
endmodule

// File: rtl/viol_capture_core.sv
// Status bit and first-violation capture registers.
// Assumes: event is a one-cycle pulse; event wins over a clear command.
module viol_capture_core
    import viol_capture_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [MID_W-1:0]  ev_master_i,
    input  logic              ev_secure_i,
    input  logic              ev_lut_bit_i,
    input  logic              clr_cmd_i,
    input  logic              set_cmd_i,
    output logic              stat_o,
    output logic [ADDR_W-1:0] info1_o,
    output info2_t            info2_o
);
    logic capture;

    assign capture = ev_valid_i && !stat_o;

    // Status: an event has top priority, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= 1'b0;
        end else if (ev_valid_i || set_cmd_i) begin
            stat_o <= 1'b1;
        end else if (clr_cmd_i) begin
            stat_o <= 1'b0;
        end
    end

    // Capture registers load only on the first event after a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info1_o <= '0;
            info2_o <= '0;
        end else if (capture) begin
            info1_o         <= ev_addr_i;
            info2_o.rsvd    <= '0;
            info2_o.lut_bit <= ev_lut_bit_i;
            info2_o.nonsec  <= ~ev_secure_i;
            info2_o.master  <= ev_master_i;
        end
    end
endmodule

// File: rtl/viol_irq_ctrl.sv
// Interrupt enable register, interrupt level and bus-error response.
// Assumes: lockdown is a level from the control block that owns it.
module viol_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_we_i,
    input  logic en_wbit_i,
    input  logic lockdown_i,
    input  logic stat_i,
    input  logic ev_valid_i,
    input  logic err_resp_i,
    output logic en_o,
    output logic irq_o,
    output logic bus_err_o
);
    // Enable register: resets to 1, write-protected under lockdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b1;
        end else if (en_we_i && !lockdown_i) begin
            en_o <= en_wbit_i;
        end
    end

    // Level interrupt and per-access error response.
    always_comb begin
        irq_o     = stat_i && en_o;
        bus_err_o = ev_valid_i && err_resp_i;
    end
endmodule

// File: rtl/viol_capture_irq.sv
// Top of the violation recorder: wires the register decoder, the
// capture core and the interrupt control together.
// Assumes: one register access at most per cycle.
module viol_capture_irq
    import viol_capture_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [15:0]       ev_master_i,
    input  logic              ev_secure_i,
    input  logic              ev_lut_bit_i,
    input  logic              cfg_err_resp_i,
    input  logic              cfg_lockdown_i,
    output logic              ev_bus_err_o,
    input  logic              reg_we_i,
    input  logic [2:0]        reg_idx_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    logic              stat_q;
    logic              en_q;
    logic [ADDR_W-1:0] info1_q;
    info2_t            info2_q;
    logic              clr_cmd;
    logic              set_cmd;
    logic              en_we;
    logic              en_wbit;

    viol_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_we_i   (reg_we_i),
        .reg_idx_i  (reg_idx_i),
        .reg_wdata_i(reg_wdata_i),
        .stat_i     (stat_q),
        .en_i       (en_q),
        .info1_i    (info1_q),
        .info2_i    (info2_q),
        .clr_cmd_o  (clr_cmd),
        .set_cmd_o  (set_cmd),
        .en_we_o    (en_we),
        .en_wbit_o  (en_wbit),
        .rdata_o    (reg_rdata_o)
    );

    viol_capture_core #(.ADDR_W(ADDR_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid_i  (ev_valid_i),
        .ev_addr_i   (ev_addr_i),
        .ev_master_i (ev_master_i),
        .ev_secure_i (ev_secure_i),
        .ev_lut_bit_i(ev_lut_bit_i),
        .clr_cmd_i   (clr_cmd),
        .set_cmd_i   (set_cmd),
        .stat_o      (stat_q),
        .info1_o     (info1_q),
        .info2_o     (info2_q)
    );

    viol_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we_i   (en_we),
        .en_wbit_i (en_wbit),
        .lockdown_i(cfg_lockdown_i),
        .stat_i    (stat_q),
        .ev_valid_i(ev_valid_i),
        .err_resp_i(cfg_err_resp_i),
        .en_o      (en_q),
        .irq_o     (irq_o),
        .bus_err_o (ev_bus_err_o)
    );
endmodule

// File: rtl/viol_capture_irq_chk.sv
// Checker for the violation recorder, bound to the top module.
module viol_capture_irq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid_i,
    input logic [ADDR_W-1:0] ev_addr_i,
    input logic              cfg_lockdown_i,
    input logic              reg_we_i,
    input logic [2:0]        reg_idx_i,
    input logic [31:0]       reg_wdata_i,
    input logic              irq_o,
    input logic              stat_q,
    input logic              en_q,
    input logic [ADDR_W-1:0] info1_q,
    input logic [31:0]       info2_q
);
    // The interrupt is never high without the enable.
    assert_irq_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_q);

    // First event captures its address and sets status.
    assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && !stat_q) |=> (stat_q && info1_q == $past(ev_addr_i)));

    // Capture is frozen while status is set.
    assert_capture_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && stat_q) |=> ($stable(info1_q) && $stable(info2_q) && stat_q));

    // A clear write without an event drops status.
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_idx_i == 3'd2 && reg_wdata_i[0] && !ev_valid_i) |=> !stat_q);

    // Event beats a same-cycle clear.
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_idx_i == 3'd2 && ev_valid_i) |=> stat_q);

    // Lockdown protects the enable.
    assert_lock_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_idx_i == 3'd1 && cfg_lockdown_i) |=> $stable(en_q));
endmodule

bind viol_capture_irq viol_capture_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid_i    (ev_valid_i),
    .ev_addr_i     (ev_addr_i),
    .cfg_lockdown_i(cfg_lockdown_i),
    .reg_we_i      (reg_we_i),
    .reg_idx_i     (reg_idx_i),
    .reg_wdata_i   (reg_wdata_i),
    .irq_o         (irq_o),
    .stat_q        (stat_q),
    .en_q          (en_q),
    .info1_q       (info1_q),
    .info2_q       (info2_q)
);

// File: tb/viol_capture_irq_tb_top.sv
module viol_capture_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic [15:0]       ev_master = '0;
    logic              ev_secure = 1'b0;
    logic              ev_lut = 1'b0;
    logic              cfg_err = 1'b0;
    logic              cfg_lock = 1'b0;
    logic              bus_err;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_idx = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    logic        m_stat;
    logic        m_en;
    logic [31:0] m_info1;
    logic [31:0] m_info2;

    always #(CLK_PERIOD/2) clk = ~clk;

    viol_capture_irq #(.ADDR_W(ADDR_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_valid_i    (ev_valid),
        .ev_addr_i     (ev_addr),
        .ev_master_i   (ev_master),
        .ev_secure_i   (ev_secure),
        .ev_lut_bit_i  (ev_lut),
        .cfg_err_resp_i(cfg_err),
        .cfg_lockdown_i(cfg_lock),
        .ev_bus_err_o  (bus_err),
        .reg_we_i      (reg_we),
        .reg_idx_i     (reg_idx),
        .reg_wdata_i   (reg_wdata),
        .reg_rdata_o   (reg_rdata),
        .irq_o         (irq)
    );

    function automatic logic [31:0] pack_info2(logic [15:0] mid, logic sec, logic lut);
        return {14'b0, lut, ~sec, mid};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(string req, logic [2:0] idx, logic [31:0] exp);
        reg_idx = idx;
        reg_we  = 1'b0;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Check every observable state against the model.
    task automatic check_all(string tag);
        check({tag, " R1 irq"}, {31'b0, irq}, {31'b0, m_stat & m_en});
        read_chk({tag, " R10 stat"}, 3'd0, {31'b0, m_stat});
        read_chk({tag, " R9 en"}, 3'd1, {31'b0, m_en});
        read_chk({tag, " R2 info1"}, 3'd4, m_info1);
        read_chk({tag, " R3 info2"}, 3'd5, m_info2);
    endtask

    // One clock: drive at negedge, apply model after the edge.
    task automatic step(logic ev, logic [31:0] a, logic [15:0] mid, logic sec, logic lut,
                        logic we, logic [2:0] idx, logic [31:0] wd, logic lock, logic errc);
        @(negedge clk);
        ev_valid = ev; ev_addr = a; ev_master = mid; ev_secure = sec; ev_lut = lut;
        reg_we = we; reg_idx = idx; reg_wdata = wd; cfg_lock = lock; cfg_err = errc;
        #1;
        check("R7 bus error", {31'b0, bus_err}, {31'b0, ev & errc});
        @(posedge clk);
        if (ev && !m_stat) begin
            m_info1 = a;
            m_info2 = pack_info2(mid, sec, lut);
        end
        if (ev) m_stat = 1'b1;
        else if (we && idx == 3'd3 && wd[0]) m_stat = 1'b1;
        else if (we && idx == 3'd2 && wd[0]) m_stat = 1'b0;
        if (we && idx == 3'd1 && !lock) m_en = wd[0];
        #2;
        ev_valid = 1'b0; reg_we = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        m_stat = 1'b0; m_en = 1'b1; m_info1 = '0; m_info2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R6 reset state
        check("R6 irq after reset", {31'b0, irq}, 32'd0);
        check_all("R6 reset");
        read_chk("R10 clr reads zero", 3'd2, 32'd0);
        read_chk("R10 set reads zero", 3'd3, 32'd0);
        read_chk("R10 idx6 zero", 3'd6, 32'd0);
        read_chk("R10 idx7 zero", 3'd7, 32'd0);

        // R2/R3 first capture, distinct fields
        step(1, 32'hDEAD_BEEF, 16'hA5C3, 1'b0, 1'b1, 0, 0, 0, 0, 1);
        check_all("R2 first");
        check("R3 layout", m_info2, 32'h0003_A5C3);
        // R4 second event frozen
        step(1, 32'h1234_5678, 16'h0F0F, 1'b1, 1'b0, 0, 0, 0, 0, 0);
        check_all("R4 frozen");
        // R5 clear with bit0 low ignored, then real clear
        step(0, 0, 0, 0, 0, 1, 3'd2, 32'hFFFF_FFFE, 0, 0);
        check_all("R5 clear bit0 low");
        step(0, 0, 0, 0, 0, 1, 3'd2, 32'd1, 0, 0);
        check_all("R5 clear");
        // R8 clear and event together
        step(1, 32'h0000_0040, 16'h1111, 1'b1, 1'b0, 1, 3'd2, 32'd1, 0, 0);
        check_all("R8 coincident");
        check("R8 status", {31'b0, m_stat}, 32'd1);
        // R9 lockdown, bit0 only
        step(0, 0, 0, 0, 0, 1, 3'd1, 32'd0, 1, 0);
        check_all("R9 locked");
        step(0, 0, 0, 0, 0, 1, 3'd1, 32'hFFFF_FFFE, 0, 0);
        check_all("R9 bit0 only");
        // R5 set write
        step(0, 0, 0, 0, 0, 1, 3'd2, 32'd1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 3'd3, 32'd0, 0, 0);
        check_all("R5 set bit0 low");
        step(0, 0, 0, 0, 0, 1, 3'd3, 32'd1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 3'd1, 32'd1, 0, 0);
        check_all("R5 set R1 irq");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic        ev   = ($urandom % 3) == 0;
            logic        we   = ($urandom % 2) == 0;
            logic [2:0]  idx  = 3'($urandom % 8);
            logic [31:0] wd   = $urandom;
            step(ev, $urandom, 16'($urandom), 1'($urandom), 1'($urandom),
                 we, idx, wd, ($urandom % 4) == 0, 1'($urandom));
            check_all("rand");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule